// File: doc/BRIEF.md
# Serial Channel Hardware Handshake Controller

This block provides the hardware handshake logic for one asynchronous serial channel. On the transmit side, it decides whether the transmitter may launch its next character. The decision depends on the active-low clear-to-send pin and a transmit flow-control enable. A character that is already being shifted out is never cut short. The gating acts only on the transmitter's request to start a new character.

On the receive side, it drives the active-low request-to-send pin. The pin goes high, which asks the far end to pause, when the receive FIFO holds at least a programmable number of bytes. It also goes high whenever a software override bit is set.

The block also watches the synchronized clear-to-send level for changes. It raises a sticky interrupt flag when a change matches the selected trigger condition. Software clears the flag with a write-one-to-clear strobe.

Top module: `uart_handshake`

## Requirements
- R1: After reset, while reset is held and until the first clock edge after its release, `rts_n` is 1, `cts_irq` is 0 and `tx_permit` is 1.
- R2: With `tx_fc_en` = 0, `tx_permit` is 1 and `tx_launch` equals `tx_start_req`, whatever the level of `cts_n`.
- R3: With `tx_fc_en` = 1, `tx_permit` equals the inverse of `cts_n` as seen through a two-flop synchronizer. A change on `cts_n` that is set up before clock edge k shows at `tx_permit` after edge k+1. `tx_permit` still holds its old value after edge k.
- R4: `tx_launch` is 1 only while `tx_start_req` is 1 and `tx_permit` is 1. A high `cts_n` therefore holds back only the start of the next character.
- R5: With `rx_fc_en` = 1 and `rts_force` = 0, `rts_n` is 1 one clock after `rx_level` > `rts_trig`, and 0 one clock after `rx_level` <= `rts_trig`. A 4-bit trigger value n thus means n+1 bytes, and `rx_level` is a 5-bit byte count from 0 to 16.
- R6: `rts_force` = 1 drives `rts_n` to 1 one clock later, whatever `rx_level`, `rts_trig` or `rx_fc_en` is.
- R7: With `rx_fc_en` = 0 and `rts_force` = 0, `rts_n` is 0 one clock later, whatever the FIFO level.
- R8: `cts_irq_sel` selects the trigger condition. 00 means none, 01 means a rise of `cts_n` (0 to 1), 10 means a fall (1 to 0), and 11 means either. A matching change on `cts_n`, set up before edge k, sets `cts_irq` after edge k+2.
- R9: `cts_irq` stays 1 until a cycle with `cts_irq_clr` = 1 clears it. If a new matching change is detected in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send pin, low means the far end accepts data |
| tx_fc_en | input | 1 | Transmit flow-control enable |
| tx_start_req | input | 1 | Transmitter is at a character boundary and wants to start a character |
| tx_permit | output | 1 | Transmitter may start a character |
| tx_launch | output | 1 | Start request granted this cycle |
| rx_fc_en | input | 1 | Receive flow-control enable |
| rts_force | input | 1 | Software override that forces a pause request |
| rts_trig | input | 4 | Trigger level, value n means n+1 bytes |
| rx_level | input | 5 | Receive FIFO byte count |
| rts_n | output | 1 | Request-to-send pin, high asks the far end to pause |
| cts_irq_sel | input | 2 | CTS interrupt condition |
| cts_irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| cts_irq | output | 1 | Sticky CTS change interrupt flag |

## Verification
Suppose the synchronizer chain or the edge-history register holds the wrong value. Within two clocks of a CTS change, `tx_permit` would show the wrong level, or `tx_permit` would move one edge early or late. One clock after that, a spurious or missing `cts_irq` would appear. A wrong RTS register or threshold comparison shows on `rts_n` one clock after the FIFO level crosses the trigger. The bench therefore sweeps every trigger against every level, and samples each response exactly at its expected cycle and one cycle before it.

// File: rtl/uhs_pkg.sv
package uhs_pkg;
  typedef enum logic [1:0] {
    IRQ_OFF  = 2'b00,
    IRQ_RISE = 2'b01,
    IRQ_FALL = 2'b10,
    IRQ_BOTH = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/uhs_cts_sync.sv
module uhs_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  // next state: shift the pin into the chain
  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = pin;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], pin};
    end
  endgenerate

  always_comb prev_d = chain_q[STAGES-1];

  // registers, idle level high (paused)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  always_comb begin
    lvl  = chain_q[STAGES-1];
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
  end
endmodule

// File: rtl/uhs_tx_gate.sv
module uhs_tx_gate (
  input  logic fc_en,
  input  logic cts_lvl,
  input  logic start_req,
  output logic permit,
  output logic launch
);
  // gating acts only on the start of a new character
  always_comb begin
    permit = ~fc_en | ~cts_lvl;
    launch = start_req & permit;
  end
endmodule

// File: rtl/uhs_rts_ctl.sv
module uhs_rts_ctl #(
  parameter int TRIG_W = 4,
  parameter int LVL_W  = TRIG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_en,
  input  logic              force_pause,
  input  logic [TRIG_W-1:0] trig,
  input  logic [LVL_W-1:0]  level,
  output logic              rts_n
);
  localparam int PAD_W = LVL_W - TRIG_W;

  logic [LVL_W-1:0] trig_ext;
  logic             full;
  logic             rts_d, rts_q;

  always_comb begin
    trig_ext = {{PAD_W{1'b0}}, trig};
    full     = level > trig_ext;        // level >= trig + 1
    rts_d    = force_pause | (fc_en & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= 1'b1;
    else        rts_q <= rts_d;
  end

  assign rts_n = rts_q;
endmodule

// File: rtl/uhs_irq.sv
module uhs_irq
  import uhs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise,
  input  logic      fall,
  input  irq_mode_e mode,
  input  logic      clr,
  output logic      flag
);
  logic hit, flag_d, flag_q;

  always_comb begin
    unique case (mode)
      IRQ_RISE: hit = rise;
      IRQ_FALL: hit = fall;
      IRQ_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
    flag_d = hit | (flag_q & ~clr);     // new event wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/uart_handshake.sv
module uart_handshake
  import uhs_pkg::*;
#(
  parameter int TRIG_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = TRIG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_n,
  input  logic              tx_fc_en,
  input  logic              tx_start_req,
  output logic              tx_permit,
  output logic              tx_launch,
  input  logic              rx_fc_en,
  input  logic              rts_force,
  input  logic [TRIG_W-1:0] rts_trig,
  input  logic [LVL_W-1:0]  rx_level,
  output logic              rts_n,
  input  logic [1:0]        cts_irq_sel,
  input  logic              cts_irq_clr,
  output logic              cts_irq
);
  logic      cts_lvl, cts_rise, cts_fall;
  irq_mode_e irq_mode;

  assign irq_mode = irq_mode_e'(cts_irq_sel);

  uhs_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cts_n),
    .lvl(cts_lvl), .rise(cts_rise), .fall(cts_fall)
  );

  uhs_tx_gate u_gate (
    .fc_en(tx_fc_en), .cts_lvl(cts_lvl), .start_req(tx_start_req),
    .permit(tx_permit), .launch(tx_launch)
  );

  uhs_rts_ctl #(.TRIG_W(TRIG_W), .LVL_W(LVL_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .fc_en(rx_fc_en), .force_pause(rts_force),
    .trig(rts_trig), .level(rx_level), .rts_n(rts_n)
  );

  uhs_irq u_irq (
    .clk(clk), .rst_n(rst_n), .rise(cts_rise), .fall(cts_fall),
    .mode(irq_mode), .clr(cts_irq_clr), .flag(cts_irq)
  );
endmodule

// File: rtl/uart_handshake_chk.sv
module uart_handshake_chk #(
  parameter int TRIG_W = 4,
  parameter int LVL_W  = TRIG_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cts_lvl,
  input logic              tx_fc_en,
  input logic              tx_start_req,
  input logic              tx_launch,
  input logic              rx_fc_en,
  input logic              rts_force,
  input logic [TRIG_W-1:0] rts_trig,
  input logic [LVL_W-1:0]  rx_level,
  input logic              rts_n,
  input logic [1:0]        cts_irq_sel,
  input logic              cts_irq_clr,
  input logic              cts_irq
);
  // R4
  launch_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_launch |-> tx_start_req);
  // R3
  launch_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_launch && tx_fc_en) |-> !cts_lvl);
  // R6
  force_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rts_force |=> rts_n);
  // R5
  level_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fc_en && ({1'b0, rts_trig} < rx_level)) |=> rts_n);
  // R7
  fc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_fc_en && !rts_force) |=> !rts_n);
  // R8
  irq_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_irq && cts_irq_sel == 2'b00) |=> !cts_irq);
  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_irq && !cts_irq_clr) |=> cts_irq);
endmodule

bind uart_handshake uart_handshake_chk #(.TRIG_W(TRIG_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cts_lvl(cts_lvl), .tx_fc_en(tx_fc_en),
  .tx_start_req(tx_start_req), .tx_launch(tx_launch), .rx_fc_en(rx_fc_en),
  .rts_force(rts_force), .rts_trig(rts_trig), .rx_level(rx_level),
  .rts_n(rts_n), .cts_irq_sel(cts_irq_sel), .cts_irq_clr(cts_irq_clr),
  .cts_irq(cts_irq)
);

// File: tb/uart_handshake_test.sv
module uart_handshake_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cts_n, tx_fc_en, tx_start_req, rx_fc_en, rts_force, cts_irq_clr;
  logic [3:0] rts_trig;
  logic [4:0] rx_level;
  logic [1:0] cts_irq_sel;
  logic       tx_permit, tx_launch, rts_n, cts_irq;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  uart_handshake uut (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .tx_fc_en(tx_fc_en),
    .tx_start_req(tx_start_req), .tx_permit(tx_permit), .tx_launch(tx_launch),
    .rx_fc_en(rx_fc_en), .rts_force(rts_force), .rts_trig(rts_trig),
    .rx_level(rx_level), .rts_n(rts_n), .cts_irq_sel(cts_irq_sel),
    .cts_irq_clr(cts_irq_clr), .cts_irq(cts_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cts_n = 1'b1; tx_fc_en = 1'b0; tx_start_req = 1'b0;
    rx_fc_en = 1'b0; rts_force = 1'b0; rts_trig = 4'd0; rx_level = 5'd0;
    cts_irq_sel = 2'b00; cts_irq_clr = 1'b0;
    step(3);
    // R1 reset state
    check("R1 rts_n", int'(rts_n), 1);
    check("R1 cts_irq", int'(cts_irq), 0);
    check("R1 tx_permit", int'(tx_permit), 1);
    rst_n = 1'b1;
    check("R1 rts_n before edge", int'(rts_n), 1);
    step(1);
    // R7 enables clear, no force
    check("R7 rts_n low", int'(rts_n), 0);

    // R2 transmit gating disabled: sweep cts and request
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 2; r++) begin
        cts_n = c[0]; tx_start_req = r[0];
        step(3);
        check("R2 tx_permit", int'(tx_permit), 1);
        check("R2 tx_launch", int'(tx_launch), r);
      end
    end

    // R3/R4 gating enabled, with latency
    tx_fc_en = 1'b1;
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 2; r++) begin
        cts_n = c[0]; tx_start_req = r[0];
        step(3);
        check("R3 tx_permit", int'(tx_permit), 1 - c);
        check("R4 tx_launch", int'(tx_launch), r & (1 - c));
      end
    end
    tx_start_req = 1'b1;
    cts_n = 1'b0;
    step(1);
    check("R3 permit one edge after", int'(tx_permit), 0);
    step(1);
    check("R3 permit two edges after", int'(tx_permit), 1);
    check("R4 launch granted", int'(tx_launch), 1);
    cts_n = 1'b1;
    step(1);
    check("R4 launch before sync", int'(tx_launch), 1);
    step(1);
    check("R4 launch held", int'(tx_launch), 0);
    tx_start_req = 1'b0; tx_fc_en = 1'b0;

    // R5 full sweep of trigger against level
    rx_fc_en = 1'b1;
    for (int t = 0; t < 16; t++) begin
      for (int l = 0; l <= 16; l++) begin
        rts_trig = 4'(t); rx_level = 5'(l);
        step(1);
        check("R5 rts_n", int'(rts_n), (l >= t + 1) ? 1 : 0);
      end
    end
    // R5 one-cycle latency on a crossing
    rts_trig = 4'd7; rx_level = 5'd7;
    step(1);
    rx_level = 5'd8;
    #1 check("R5 rts_n before edge", int'(rts_n), 0);
    step(1);
    check("R5 rts_n after edge", int'(rts_n), 1);

    // R6 force at every level, both enable settings
    for (int e = 0; e < 2; e++) begin
      for (int l = 0; l <= 16; l += 4) begin
        rx_fc_en = e[0]; rts_force = 1'b1; rts_trig = 4'd15; rx_level = 5'(l);
        step(1);
        check("R6 rts_n forced", int'(rts_n), 1);
        rts_force = 1'b0;
        step(1);
        check("R6 rts_n released", int'(rts_n), (e == 1 && l == 16) ? 1 : 0);
      end
    end
    // R7 disable ignores a full FIFO
    rx_fc_en = 1'b0; rx_level = 5'd16; rts_trig = 4'd0;
    step(1);
    check("R7 rts_n disabled", int'(rts_n), 0);

    // R8 interrupt condition sweep
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 2; d++) begin
        cts_irq_sel = 2'(s);
        cts_n = d[0] ? 1'b0 : 1'b1;   // d=1 tests rise, d=0 tests fall
        step(4);
        cts_irq_clr = 1'b1;
        step(1);
        cts_irq_clr = 1'b0;
        check("R8 irq cleared", int'(cts_irq), 0);
        cts_n = ~cts_n;
        step(2);
        check("R8 irq not early", int'(cts_irq), 0);
        step(1);
        check("R8 irq", int'(cts_irq),
              (s == 3 || (s == 1 && d == 1) || (s == 2 && d == 0)) ? 1 : 0);
      end
    end

    // R9 sticky and set-wins-over-clear
    cts_irq_sel = 2'b11;
    step(5);
    check("R9 irq sticky", int'(cts_irq), 1);
    cts_n = ~cts_n;
    step(2);
    cts_irq_clr = 1'b1;
    step(1);
    cts_irq_clr = 1'b0;
    check("R9 set wins", int'(cts_irq), 1);
    cts_irq_clr = 1'b1;
    step(1);
    cts_irq_clr = 1'b0;
    check("R9 clear", int'(cts_irq), 0);
    step(3);
    check("R9 stays clear", int'(cts_irq), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule